// File: doc/BRIEF.md
# Write-Protected Rheostat Command Processor

This block sits between a serial slave front end and a small non-volatile slot store. It turns each 16-bit command word into an action on a 10-bit wiper code, a two-bit control register and a shutdown flag. It can also ask the slot store to save the current wiper code. Two control bits protect the block, and both are cleared at reset. One lets the wiper be written. The other allows a store to memory.

Read commands do not answer in the same cycle. They load a 16-bit read word, and the serial front end shifts that word out during the next frame. A hardware reset pin and a software reset command both reload the wiper from the last value held in the slot store. While the slot store is busy programming, every incoming command is discarded.

Top module: `rheo_cmd_proc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the wiper loads `slot_last_word`, both control bits and the shutdown flag clear, and `rd_word` clears.
- R2: The command code is word bits 13:10 and the data is bits 9:0. Code 1 loads the data into the wiper one cycle after the strobe when the wiper-write bit is 1. A word whose bits 15:14 are not both zero acts as a no-op.
- R3: While the wiper-write bit is 0, code 1 leaves the wiper unchanged.
- R4: Code 7 copies data bit 0 into the program-enable bit and data bit 1 into the wiper-write bit. Data bits 9:2 have no effect.
- R5: Code 3 pulses `slot_store_stb` for exactly one cycle, with `slot_store_data` equal to the wiper, only when program-enable is 1.
- R6: Code 4 reloads the wiper from `slot_last_word` whatever the wiper-write bit is, and it clears shutdown.
- R7: A low `hw_rst_n` at a clock edge reloads the wiper from `slot_last_word` and clears shutdown. It also discards any command strobed in that cycle.
- R8: Code 9 sets shutdown to data bit 0. Shutdown then persists across other commands, and those commands still take effect.
- R9: Read codes load `rd_word` one cycle after the strobe. The value is right-aligned with zeros above it:
  - code 2 gives the wiper;
  - code 5 gives `slot_rd_data` for slot address data bits 5:0, which is driven out on `slot_rd_addr`;
  - code 6 gives `slot_last_idx`;
  - code 8 gives `{slot_ok, 0, wiper-write, program-enable}` in bits 3:0.
- R10: Codes other than 2, 5, 6 and 8, including codes 10 to 15, leave `rd_word` unchanged.
- R11: While `slot_busy` is high, strobed commands change neither the wiper, the shutdown flag, the control bits nor `rd_word`, and they raise no store strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| hw_rst_n | input | 1 | Active-low hardware reload request |
| cmd_stb | input | 1 | One-cycle strobe marking a complete command word |
| cmd_word | input | 16 | Command word: pad, code, data |
| slot_busy | input | 1 | Slot store is programming |
| slot_ok | input | 1 | Slot store reports last program succeeded |
| slot_last_word | input | 10 | Most recently stored wiper value (or midscale) |
| slot_rd_data | input | 10 | Contents of slot at `slot_rd_addr` |
| slot_last_idx | input | 6 | Index of most recently programmed slot |
| wiper | output | 10 | Wiper code |
| shutdown | output | 1 | Shutdown state |
| slot_store_stb | output | 1 | Request to store wiper into next slot |
| slot_store_data | output | 10 | Value to store |
| slot_rd_addr | output | 6 | Slot address taken from command data bits 5:0 |
| rd_word | output | 16 | Word staged for the next read frame |

## Verification
All 1024 wiper codes are written and then read back, so both the data field position and the read alignment are exercised. All 64 slot addresses are read against arithmetic contents, which separates a wrong address slice from a wrong data mux. Every command code, including the undefined ones, is sent after a read, which separates read codes from the rest. The protection bits, shutdown persistence, hardware reset against a simultaneous command, and busy dropping are each set up in both polarities, so that a stuck gate or a reversed priority shows up as a wrong wiper, flag or strobe.

// File: rtl/rheo_cmd_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the rheostat command processor.
// Assumes a 4-bit command code and a 2-bit zero pad above it.
package rheo_cmd_pkg;
    localparam int CMD_W = 4;
    localparam int PAD_W = 2;
    localparam int CTRL_RD_W = 4;

    localparam logic [CMD_W-1:0] C_WR_WIPER = 4'd1;
    localparam logic [CMD_W-1:0] C_RD_WIPER = 4'd2;
    localparam logic [CMD_W-1:0] C_STORE    = 4'd3;
    localparam logic [CMD_W-1:0] C_SW_RESET = 4'd4;
    localparam logic [CMD_W-1:0] C_RD_SLOT  = 4'd5;
    localparam logic [CMD_W-1:0] C_RD_LAST  = 4'd6;
    localparam logic [CMD_W-1:0] C_WR_CTRL  = 4'd7;
    localparam logic [CMD_W-1:0] C_RD_CTRL  = 4'd8;
    localparam logic [CMD_W-1:0] C_SHDN     = 4'd9;

    // At most one flag is set, and only for an accepted command.
    typedef struct packed {
        logic wr_wiper;
        logic rd_wiper;
        logic store;
        logic sw_reset;
        logic rd_slot;
        logic rd_last;
        logic wr_ctrl;
        logic rd_ctrl;
        logic shdn;
    } op_flags_t;
endpackage

// File: rtl/rheo_decode.sv
`timescale 1ns/1ps
// Command decoder: turns a strobed word into one operation flag.
// It drops the command when the slot store is busy, when a hardware
// reload is active, or when the pad bits are nonzero.
// Assumes cmd_word is stable in the cycle cmd_stb is high.
module rheo_decode
    import rheo_cmd_pkg::*;
#(
    parameter int DATA_W = 10,
    localparam int WORD_W = DATA_W + CMD_W + PAD_W
) (
    input  logic              cmd_stb,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              slot_busy,
    input  logic              hw_rst_n,
    output op_flags_t         ops,
    output logic [DATA_W-1:0] data
);
    logic [CMD_W-1:0] code;
    logic [PAD_W-1:0] pad;
    logic             accept;

    assign code   = cmd_word[DATA_W +: CMD_W];
    assign pad    = cmd_word[WORD_W-1 -: PAD_W];
    assign data   = cmd_word[DATA_W-1:0];
    assign accept = cmd_stb && !slot_busy && hw_rst_n && (pad == '0);

    // Map the accepted code onto its single operation flag.
    always_comb begin
        ops = '0;
        if (accept) begin
            case (code)
                C_WR_WIPER: ops.wr_wiper = 1'b1;
                C_RD_WIPER: ops.rd_wiper = 1'b1;
                C_STORE:    ops.store    = 1'b1;
                C_SW_RESET: ops.sw_reset = 1'b1;
                C_RD_SLOT:  ops.rd_slot  = 1'b1;
                C_RD_LAST:  ops.rd_last  = 1'b1;
                C_WR_CTRL:  ops.wr_ctrl  = 1'b1;
                C_RD_CTRL:  ops.rd_ctrl  = 1'b1;
                C_SHDN:     ops.shdn     = 1'b1;
                default:    ops = '0;
            endcase
        end
    end
endmodule

// File: rtl/rheo_ctrl.sv
`timescale 1ns/1ps
// Control state: the program-enable bit, the wiper-write bit and the
// shutdown flag. Both protection bits clear on block reset only.
// Shutdown clears on block reset, hardware reload or software reset.
module rheo_ctrl
    import rheo_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_rst_n,
    input  op_flags_t  ops,
    input  logic [1:0] ctl_bits,
    output logic       pen,
    output logic       wen,
    output logic       shutdown
);
    // Protection bits: loaded only by the control-write command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen <= 1'b0;
            wen <= 1'b0;
        end else if (ops.wr_ctrl) begin
            pen <= ctl_bits[0];
            wen <= ctl_bits[1];
        end
    end

    // Shutdown flag: set or cleared by its command, cleared by resets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown <= 1'b0;
        end else if (!hw_rst_n || ops.sw_reset) begin
            shutdown <= 1'b0;
        end else if (ops.shdn) begin
            shutdown <= ctl_bits[0];
        end
    end

    p_shdn_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> !shutdown);

    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ops.wr_ctrl |=> $stable({pen, wen}));
endmodule

// File: rtl/rheo_wiper.sv
`timescale 1ns/1ps
// Wiper register and store request. Reload from the slot store wins
// over a write. A write needs the wiper-write bit, and a store needs
// the program-enable bit. The store strobe is registered and lasts
// one cycle.
module rheo_wiper
    import rheo_cmd_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  op_flags_t         ops,
    input  logic [DATA_W-1:0] data,
    input  logic              wen,
    input  logic              pen,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] wiper,
    output logic              store_stb,
    output logic [DATA_W-1:0] store_data
);
    // Wiper update: reload on any reset, otherwise a protected write.
    always_ff @(posedge clk) begin
        if (!rst_n || !hw_rst_n || ops.sw_reset) begin
            wiper <= reload_val;
        end else if (ops.wr_wiper && wen) begin
            wiper <= data;
        end
    end

    // Store request: one-cycle pulse carrying the current wiper.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_stb  <= 1'b0;
            store_data <= '0;
        end else begin
            store_stb <= ops.store && pen;
            if (ops.store && pen) begin
                store_data <= wiper;
            end
        end
    end

    p_locked_wiper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rst_n && !ops.sw_reset && !wen) |=> $stable(wiper));

    p_store_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |-> $past(pen));
endmodule

// File: rtl/rheo_readback.sv
`timescale 1ns/1ps
// Read word staging: a read command loads the word for the next frame,
// right-aligned with zeros above. Other commands leave it unchanged.
module rheo_readback
    import rheo_cmd_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int SLOT_AW = 6,
    localparam int WORD_W = DATA_W + CMD_W + PAD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  op_flags_t          ops,
    input  logic [DATA_W-1:0]  wiper,
    input  logic [DATA_W-1:0]  slot_rd_data,
    input  logic [SLOT_AW-1:0] slot_last_idx,
    input  logic               slot_ok,
    input  logic               wen,
    input  logic               pen,
    output logic [WORD_W-1:0]  rd_word
);
    logic [CTRL_RD_W-1:0] ctrl_img;
    logic                 any_rd;

    assign ctrl_img = {slot_ok, 1'b0, wen, pen};
    assign any_rd   = ops.rd_wiper || ops.rd_slot || ops.rd_last || ops.rd_ctrl;

    // Select the source named by the read command and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (ops.rd_wiper) begin
            rd_word <= WORD_W'(wiper);
        end else if (ops.rd_slot) begin
            rd_word <= WORD_W'(slot_rd_data);
        end else if (ops.rd_last) begin
            rd_word <= WORD_W'(slot_last_idx);
        end else if (ops.rd_ctrl) begin
            rd_word <= WORD_W'(ctrl_img);
        end
    end

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rd |=> $stable(rd_word));
endmodule

// File: rtl/rheo_cmd_proc.sv
`timescale 1ns/1ps
// Top level of the write-protected rheostat command processor.
// It wires the decoder, control state, wiper and read staging.
// Assumes one command per strobe and a slot store that answers
// slot_rd_data combinationally from slot_rd_addr.
module rheo_cmd_proc
    import rheo_cmd_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int SLOT_AW = 6,
    localparam int WORD_W = DATA_W + CMD_W + PAD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_rst_n,
    input  logic               cmd_stb,
    input  logic [WORD_W-1:0]  cmd_word,
    input  logic               slot_busy,
    input  logic               slot_ok,
    input  logic [DATA_W-1:0]  slot_last_word,
    input  logic [DATA_W-1:0]  slot_rd_data,
    input  logic [SLOT_AW-1:0] slot_last_idx,
    output logic [DATA_W-1:0]  wiper,
    output logic               shutdown,
    output logic               slot_store_stb,
    output logic [DATA_W-1:0]  slot_store_data,
    output logic [SLOT_AW-1:0] slot_rd_addr,
    output logic [WORD_W-1:0]  rd_word
);
    op_flags_t         ops;
    logic [DATA_W-1:0] data;
    logic              pen;
    logic              wen;

    assign slot_rd_addr = data[SLOT_AW-1:0];

    rheo_decode #(.DATA_W(DATA_W)) u_decode (
        .cmd_stb   (cmd_stb),
        .cmd_word  (cmd_word),
        .slot_busy (slot_busy),
        .hw_rst_n  (hw_rst_n),
        .ops       (ops),
        .data      (data)
    );

    rheo_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_rst_n (hw_rst_n),
        .ops      (ops),
        .ctl_bits (data[1:0]),
        .pen      (pen),
        .wen      (wen),
        .shutdown (shutdown)
    );

    rheo_wiper #(.DATA_W(DATA_W)) u_wiper (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_rst_n   (hw_rst_n),
        .ops        (ops),
        .data       (data),
        .wen        (wen),
        .pen        (pen),
        .reload_val (slot_last_word),
        .wiper      (wiper),
        .store_stb  (slot_store_stb),
        .store_data (slot_store_data)
    );

    rheo_readback #(.DATA_W(DATA_W), .SLOT_AW(SLOT_AW)) u_readback (
        .clk           (clk),
        .rst_n         (rst_n),
        .ops           (ops),
        .wiper         (wiper),
        .slot_rd_data  (slot_rd_data),
        .slot_last_idx (slot_last_idx),
        .slot_ok       (slot_ok),
        .wen           (wen),
        .pen           (pen),
        .rd_word       (rd_word)
    );

    p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_busy && hw_rst_n) |=> ($stable(wiper) && $stable(shutdown)
                                     && $stable(rd_word) && !slot_store_stb));
endmodule

// File: tb/rheo_cmd_proc_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps wiper codes, slot addresses and command
// codes, with expected values computed arithmetically.
module rheo_cmd_proc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_rst_n = 1'b1;
    logic        cmd_stb = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        slot_busy = 1'b0;
    logic        slot_ok = 1'b0;
    logic [9:0]  slot_last_word = 10'h200;
    logic [9:0]  slot_rd_data;
    logic [5:0]  slot_last_idx = 6'd0;
    logic [9:0]  wiper;
    logic        shutdown;
    logic        slot_store_stb;
    logic [9:0]  slot_store_data;
    logic [5:0]  slot_rd_addr;
    logic [15:0] rd_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    function automatic logic [9:0] slot_val(input logic [5:0] a);
        return 10'((int'(a) * 37 + 5) % 1024);
    endfunction

    assign slot_rd_data = slot_val(slot_rd_addr);

    rheo_cmd_proc dut_i (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .cmd_stb(cmd_stb),
        .cmd_word(cmd_word), .slot_busy(slot_busy), .slot_ok(slot_ok),
        .slot_last_word(slot_last_word), .slot_rd_data(slot_rd_data),
        .slot_last_idx(slot_last_idx), .wiper(wiper), .shutdown(shutdown),
        .slot_store_stb(slot_store_stb), .slot_store_data(slot_store_data),
        .slot_rd_addr(slot_rd_addr), .rd_word(rd_word)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int code, input logic [9:0] d);
        return {2'b00, 4'(code), d};
    endfunction

    // Strobe one word; returns at the falling edge after it took effect.
    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_word = w;
        cmd_stb  = 1'b1;
        @(negedge clk);
        cmd_stb  = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired before the run completed");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wiper", 16'(wiper), 16'h200);
        chk("R1 shutdown", 16'(shutdown), 16'h0);
        chk("R1 rd_word", rd_word, 16'h0);
        chk("R1 store_stb", 16'(slot_store_stb), 16'h0);
        send(mk(8, 10'h0));
        chk("R1 ctrl cleared", rd_word, 16'h0);

        // R3 wiper write ignored while protected
        send(mk(1, 10'h155));
        chk("R3 locked wiper", 16'(wiper), 16'h200);

        // R4 control write uses only bits 1:0
        send(mk(7, 10'h3FE));
        send(mk(8, 10'h0));
        chk("R4 ctrl wen only", rd_word, 16'h0002);
        slot_ok = 1'b1;
        send(mk(7, 10'h003));
        send(mk(8, 10'h0));
        chk("R9 ctrl image", rd_word, 16'h000B);
        slot_ok = 1'b0;

        // R2 R9 sweep all wiper codes with readback
        for (int v = 0; v < 1024; v++) begin
            send(mk(1, 10'(v)));
            chk("R2 wiper write", 16'(wiper), 16'(v));
            send(mk(2, 10'h0));
            chk("R9 wiper read", rd_word, 16'(v));
        end

        // R2 nonzero pad bits make a no-op
        send(16'h4000 | mk(1, 10'h011));
        chk("R2 pad rejects", 16'(wiper), 16'h3FF);

        // R5 store with program enable, then without
        send(mk(1, 10'h123));
        send(mk(3, 10'h0));
        chk("R5 store stb", 16'(slot_store_stb), 16'h1);
        chk("R5 store data", 16'(slot_store_data), 16'h123);
        @(negedge clk);
        chk("R5 stb one cycle", 16'(slot_store_stb), 16'h0);
        send(mk(7, 10'h002));
        send(mk(3, 10'h0));
        chk("R5 store gated", 16'(slot_store_stb), 16'h0);

        // R9 slot reads over all addresses, junk in upper data bits
        for (int a = 0; a < 64; a++) begin
            send(mk(5, {4'hF, 6'(a)}));
            chk("R9 slot read", rd_word, 16'(slot_val(6'(a))));
        end
        slot_last_idx = 6'd25;
        send(mk(6, 10'h0));
        chk("R9 last idx", rd_word, 16'd25);

        // R10 non-read codes leave rd_word unchanged
        for (int c = 0; c < 16; c++) begin
            if (c == 2 || c == 5 || c == 6 || c == 8) continue;
            held = rd_word;
            send(mk(c, 10'h003));
            chk("R10 rd hold", rd_word, held);
        end

        // R8 shutdown persists, other commands execute
        send(mk(7, 10'h002));
        send(mk(9, 10'h001));
        chk("R8 enter", 16'(shutdown), 16'h1);
        send(mk(1, 10'h0AA));
        chk("R8 write in shdn", 16'(wiper), 16'h0AA);
        chk("R8 persists", 16'(shutdown), 16'h1);
        send(mk(2, 10'h0));
        chk("R8 read in shdn", rd_word, 16'h0AA);
        send(mk(9, 10'h000));
        chk("R8 leave", 16'(shutdown), 16'h0);

        // R6 software reset reloads and clears shutdown
        send(mk(9, 10'h001));
        slot_last_word = 10'h2C4;
        send(mk(4, 10'h0));
        chk("R6 reload", 16'(wiper), 16'h2C4);
        chk("R6 shdn clear", 16'(shutdown), 16'h0);
        send(mk(7, 10'h000));
        send(mk(1, 10'h011));
        chk("R3 relocked", 16'(wiper), 16'h2C4);
        slot_last_word = 10'h0F0;
        send(mk(4, 10'h0));
        chk("R6 reload protected", 16'(wiper), 16'h0F0);

        // R7 hardware reload beats a simultaneous write
        send(mk(7, 10'h002));
        send(mk(9, 10'h001));
        slot_last_word = 10'h077;
        @(negedge clk);
        hw_rst_n = 1'b0;
        cmd_word = mk(1, 10'h3FF);
        cmd_stb  = 1'b1;
        @(negedge clk);
        cmd_stb  = 1'b0;
        hw_rst_n = 1'b1;
        chk("R7 reload", 16'(wiper), 16'h077);
        chk("R7 shdn clear", 16'(shutdown), 16'h0);

        // R11 busy drops commands
        send(mk(7, 10'h003));
        send(mk(2, 10'h0));
        held = rd_word;
        slot_busy = 1'b1;
        send(mk(1, 10'h001));
        chk("R11 wiper held", 16'(wiper), 16'h077);
        send(mk(9, 10'h001));
        chk("R11 shdn held", 16'(shutdown), 16'h0);
        send(mk(3, 10'h0));
        chk("R11 no store", 16'(slot_store_stb), 16'h0);
        send(mk(7, 10'h000));
        send(mk(6, 10'h0));
        chk("R11 rd held", rd_word, held);
        slot_busy = 1'b0;
        send(mk(8, 10'h0));
        chk("R11 ctrl kept", rd_word, 16'h0003);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule